// File: doc/BRIEF.md
# Transfer Interrupt Status and Mask Unit

This unit gathers the event signals of a two-wire bus controller into one status word and drives a single interrupt line from it. Six events are one-cycle pulses that stay pending until software clears them: packet done, all packets done, transmit overflow, receive underflow, missing acknowledge and lost arbitration. Two events are level requests that stay high while a FIFO wants service: transmit data wanted and receive data available. A pending event is recorded whether or not it is enabled. The interrupt line reflects only the enabled pending bits.

Software reaches the unit through a simple register port. The enable register sits at byte offset 0x64, the pending word at 0x68, and both read back. Software changes enables by read-modify-write, and clears pending bits by writing ones to them. The missing-acknowledge event fires before the controller has put the stop condition on the bus. Software therefore has to let the stop go out before it resets the controller. This unit only records the event, so that timing is left to software.

Top module: `xfer_irq_unit`

## Requirements
- R1: The pending word has fixed bit positions: 7 packet done, 6 all packets done, 5 transmit overflow, 4 receive underflow, 3 missing acknowledge, 2 lost arbitration, 1 transmit data wanted, 0 receive data available. `evt_i[k]` feeds pending bit k.
- R2: A write to offset 0x68 clears exactly the pending bits that are one in `reg_wdata_i[7:0]`, and leaves every other bit as it was.
- R3: The interrupt line is driven only by pending bits whose enable bit is one. With the enable register at zero, `irq_o` stays low.
- R4: An event is recorded in the pending word even while its enable bit is zero.
- R5: On pulse sources (bits 7..2), an event that arrives in the same cycle as a clear of that bit wins, and the bit stays set.
- R6: On level sources (bits 1..0), a clear takes effect in the cycle it is written. If the request is still high, the bit sets again one cycle later.
- R7: `irq_o` is registered. It rises one cycle after a bit is both pending and enabled. It falls one cycle after the last such bit is cleared or disabled.
- R8: The enable register is written at offset 0x64. It reads back at 0x64 and the pending word reads back at 0x68, so a read-modify-write is possible. Bits 31..8 read as zero.
- R9: At any other offset, reads return zero and writes change nothing.
- R10: After reset the pending word, the enable register and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event inputs: pulses on bits 7..2, levels on bits 1..0 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt line |

## Verification
A write or an event seen at clock edge E shows in the pending and enable readback right after E. Its effect on `irq_o` shows only after edge E+1. The bench drives every stimulus on a falling edge and reads registers on the next falling edge. It samples `irq_o` one further falling edge later, so each check lands in the cycle where its result is due. The level-source check reads right after the clear edge and again one cycle later, which proves both the drop and the re-set. The sweeps cover every clear pattern and every enable pattern, and the bench works out each expected value with bitwise arithmetic.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    localparam int NSRC   = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // bit positions of the pending word (decoded by software)
    localparam int B_RXREQ   = 0;
    localparam int B_TXREQ   = 1;
    localparam int B_ARBLOST = 2;
    localparam int B_NOACK   = 3;
    localparam int B_RXUNDER = 4;
    localparam int B_TXOVER  = 5;
    localparam int B_ALLDONE = 6;
    localparam int B_PKTDONE = 7;

    localparam logic [NSRC-1:0] LEVEL_SRC = (NSRC'(1) << B_RXREQ) | (NSRC'(1) << B_TXREQ);

    typedef struct packed {
        logic [NSRC-1:0] pend;
    } pend_state_t;

    typedef struct packed {
        logic [NSRC-1:0] en;
    } en_state_t;

    typedef struct packed {
        logic line;
    } line_state_t;
endpackage

// File: rtl/xirq_regdec.sv
module xirq_regdec
    import xirq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EN_OFS   = 8'h64,
    parameter logic [ADDR_W-1:0] PEND_OFS = 8'h68
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NSRC-1:0]   en_q_i,
    input  logic [NSRC-1:0]   pend_q_i,
    output logic              en_we_o,
    output logic [NSRC-1:0]   en_wdata_o,
    output logic [NSRC-1:0]   clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - NSRC;

    logic hit_en, hit_pend;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[DATA_W-1:NSRC];

    always_comb begin
        hit_en     = (addr_i == EN_OFS);
        hit_pend   = (addr_i == PEND_OFS);
        en_we_o    = wr_i && hit_en;
        en_wdata_o = wdata_i[NSRC-1:0];
        clr_o      = (wr_i && hit_pend) ? wdata_i[NSRC-1:0] : '0;
        if (hit_en)
            rdata_o = {{PAD_W{1'b0}}, en_q_i};
        else if (hit_pend)
            rdata_o = {{PAD_W{1'b0}}, pend_q_i};
        else
            rdata_o = '0;
    end

    // R9: an unmapped write never strobes a register
    always_comb begin
        if (!hit_en && !hit_pend)
            a_r9_no_strobe: assert (!en_we_o && clr_o == '0);
    end
endmodule

// File: rtl/xirq_pend_bank.sv
module xirq_pend_bank
    import xirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    pend_state_t st_d, st_q;
    logic [NSRC-1:0] nxt;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (LEVEL_SRC[i]) begin : g_lvl
            // level request: clear wins, request re-sets next cycle
            assign nxt[i] = clr_i[i] ? 1'b0 : (st_q.pend[i] | evt_i[i]);

            a_r6_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i[i] |=> !pend_o[i]);
            a_r6_level_reset: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_i[i] && evt_i[i]) |=> pend_o[i]);
        end else begin : g_pls
            // sticky event: arrival wins over clear
            assign nxt[i] = evt_i[i] | (st_q.pend[i] & ~clr_i[i]);

            a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[i] |=> pend_o[i]);
            a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !evt_i[i]) |=> !pend_o[i]);
            a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_i[i] && pend_o[i]) |=> pend_o[i]);
        end
    end

    always_comb begin
        st_d.pend = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/xirq_en_reg.sv
module xirq_en_reg
    import xirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] en_o
);
    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.en = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    a_r8_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> en_o == $past(wdata_i));
    a_r8_en_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(en_o));
endmodule

// File: rtl/xirq_line.sv
module xirq_line
    import xirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] en_i,
    output logic            irq_o
);
    line_state_t st_d, st_q;

    always_comb begin
        st_d.line = |(pend_i & en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.line;

    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/xfer_irq_unit.sv
module xfer_irq_unit
    import xirq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EN_OFS   = 8'h64,
    parameter logic [ADDR_W-1:0] PEND_OFS = 8'h68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic            en_we;
    logic [NSRC-1:0] en_wdata, clr, en_q, pend_q;

    xirq_regdec #(.EN_OFS(EN_OFS), .PEND_OFS(PEND_OFS)) u_dec (
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .en_q_i     (en_q),
        .pend_q_i   (pend_q),
        .en_we_o    (en_we),
        .en_wdata_o (en_wdata),
        .clr_o      (clr),
        .rdata_o    (reg_rdata_o)
    );

    xirq_pend_bank u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (clr),
        .pend_o (pend_q)
    );

    xirq_en_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (en_we),
        .wdata_i (en_wdata),
        .en_o    (en_q)
    );

    xirq_line u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_q),
        .en_i   (en_q),
        .irq_o  (irq_o)
    );

    // R7: writing a zero enable word silences the line two edges later
    a_r7_mask_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == EN_OFS && reg_wdata_i[NSRC-1:0] == '0) |=> ##1 !irq_o);
    // R4: an event is recorded regardless of the enable word
    a_r4_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[B_NOACK] && !(reg_wr_i && reg_addr_i == PEND_OFS)) |=> pend_q[B_NOACK]);
endmodule

// File: tb/xfer_irq_unit_test.sv
module xfer_irq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [7:0] A_EN = 8'h64, A_PD = 8'h68;

    always #10 clk = ~clk;

    xfer_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // presented at a falling edge, taken at the next rising edge
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev);
        addr = a; wdata = d; wr = 1'b1; evt = ev;
        @(negedge clk);
        wr = 1'b0; evt = (evt & 8'h03);
    endtask

    task automatic pulse(input logic [7:0] ev);
        evt = (evt & 8'h03) | ev;
        @(negedge clk);
        evt = evt & 8'h03;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R10 reset state
        rd(A_PD, d); chk("R10 pending", d, 0);
        rd(A_EN, d); chk("R10 enable", d, 0);
        chk("R10 irq", {31'b0, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R4 / R3: each pulse source sets its own bit while disabled
        for (int i = 2; i < 8; i++) begin
            pulse(8'(1 << i));
            rd(A_PD, d); chk("R1 R4 bit position", d, 32'(1 << i));
            @(negedge clk);
            chk("R3 no irq while disabled", {31'b0, irq}, 0);
            wr_reg(A_PD, 32'(1 << i), 8'h00);
            rd(A_PD, d); chk("R2 single clear", d, 0);
        end

        // R2: every clear pattern against a full set of pulse bits
        for (int p = 0; p < 256; p++) begin
            pulse(8'hFC);
            wr_reg(A_PD, 32'(p) | 32'hFFFF_FF00, 8'h00);
            rd(A_PD, d); chk("R2 clear pattern", d, 32'(8'hFC & ~p[7:0]));
            wr_reg(A_PD, 32'hFF, 8'h00);
        end

        // R5: arrival wins over a clear in the same cycle
        pulse(8'h80);
        wr_reg(A_PD, 32'h80, 8'h80);
        rd(A_PD, d); chk("R5 event wins", d, 32'h80);
        wr_reg(A_PD, 32'h80, 8'h00);
        rd(A_PD, d); chk("R5 later clear", d, 0);

        // R6: level source clear and re-set
        evt = 8'h02;
        @(negedge clk);
        rd(A_PD, d); chk("R6 level sets", d, 32'h02);
        wr_reg(A_PD, 32'h02, 8'h02);
        rd(A_PD, d); chk("R6 clear cycle", d, 0);
        @(negedge clk);
        rd(A_PD, d); chk("R6 re-set", d, 32'h02);
        evt = 8'h00;
        wr_reg(A_PD, 32'h02, 8'h00);
        @(negedge clk);
        rd(A_PD, d); chk("R6 stays clear", d, 0);

        // R8: enable readback, upper bits zero
        wr_reg(A_EN, 32'hFFFF_FF08, 8'h00);
        rd(A_EN, d); chk("R8 enable readback", d, 32'h08);

        // R7 timing with enable = NACK bit
        pulse(8'h08);
        chk("R7 irq not yet", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R7 irq rises", {31'b0, irq}, 1);
        wr_reg(A_PD, 32'h08, 8'h00);
        chk("R7 irq still high", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R7 irq falls on clear", {31'b0, irq}, 0);
        pulse(8'h08);
        @(negedge clk);
        chk("R7 irq again", {31'b0, irq}, 1);
        wr_reg(A_EN, 32'h0, 8'h00);
        chk("R7 irq before mask edge", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R7 R3 irq falls on mask", {31'b0, irq}, 0);
        rd(A_PD, d); chk("R4 pending kept when masked", d, 32'h08);

        // R9: unmapped offsets
        wr_reg(8'h60, 32'hFF, 8'h00);
        wr_reg(8'h6C, 32'hFF, 8'h00);
        rd(A_PD, d); chk("R9 pending untouched", d, 32'h08);
        rd(A_EN, d); chk("R9 enable untouched", d, 0);
        rd(8'h6C, d); chk("R9 unmapped read", d, 0);
        wr_reg(A_PD, 32'hFF, 8'h00);

        // R3: all enable patterns, pending = pulse bits only
        pulse(8'hFC);
        for (int m = 0; m < 256; m++) begin
            wr_reg(A_EN, 32'(m), 8'h00);
            @(negedge clk);
            chk("R3 enable sweep", {31'b0, irq}, {31'b0, |(8'hFC & m[7:0])});
        end
        // R3: all enable patterns, only level bits pending
        wr_reg(A_PD, 32'hFF, 8'h00);
        evt = 8'h03;
        for (int m = 0; m < 256; m++) begin
            wr_reg(A_EN, 32'(m), 8'h03);
            @(negedge clk);
            chk("R3 R6 level sweep", {31'b0, irq}, {31'b0, |(8'h03 & m[7:0])});
        end
        evt = 8'h00;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule